// File: doc/BRIEF.md
# Paired Q15 Lane Adder

This block is one execution slice of a signal-processing datapath. It takes the low 32 bits of two 64-bit source operands, treats each as a pair of signed Q15 halfwords, and adds the matching halfwords. The two additions are independent. A mode input chooses between wrap-around arithmetic and clamping to the Q15 limits. The two 16-bit lane results are packed into a 64-bit destination word, and the upper 32 bits repeat the sign of the upper lane.

Whenever either lane leaves the Q15 range, the block sets a sticky overflow flag at bit 20 of a 32-bit control register. Software can overwrite that register through a separate write port. An operation starts with a one-cycle `start` pulse. When the unit is enabled, the registered result and a one-cycle `res_valid` appear on the next clock. When the unit is disabled, a one-cycle `unit_off_exc` appears instead, and no result is produced.

Top module: `q15_pair_adder`

## Requirements
- R1: The upper lane is bits 31:16 and the lower lane is bits 15:0 of each operand. No carry passes between the lanes. In wrap mode (`sat_mode`=0) each lane result is the low 16 bits of the signed sum, so it wraps modulo 2^16.
- R2: A lane overflows when its 17-bit sign-extended sum falls outside the range -32768..32767.
- R3: In saturating mode (`sat_mode`=1) an overflowing lane gives 0x7FFF for a positive overflow and 0x8000 for a negative overflow. A lane that does not overflow gives its plain sum.
- R4: `result` is laid out as follows: bits 63:32 are 32 copies of bit 15 of the upper lane result, bits 31:16 are the upper lane result, and bits 15:0 are the lower lane result.
- R5: An accepted operation in which either lane overflows sets bit 20 of `ctl_reg`, in either mode. The bit stays set through later operations that do not overflow.
- R6: If `start` is high while `dsp_en` is low, `unit_off_exc` pulses high on the next cycle. In that case `res_valid` stays low, and `result` and `ctl_reg` keep their values.
- R7: When `ctl_we` is high, `ctl_reg` takes `ctl_wdata` on the next cycle, which lets software clear bit 20. If the write coincides with an overflowing operation, bit 20 ends up 1 and the other bits come from `ctl_wdata`.
- R8: When `start` is high and `dsp_en` is high, `res_valid` is high for exactly the next cycle, with `result` valid in that cycle. `res_valid` is low in any cycle that does not follow an accepted start.
- R9: An active-low synchronous reset clears `result`, `res_valid`, `unit_off_exc` and `ctl_reg` to zero.
- R10: Bits 63:32 of both operands have no effect on `result` or on `ctl_reg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to perform an add |
| dsp_en | input | 1 | Unit enable; a start while this is low raises the exception |
| sat_mode | input | 1 | 0 selects wrap arithmetic, 1 selects saturating arithmetic |
| src_a | input | 64 | First operand; only bits 31:0 are used |
| src_b | input | 64 | Second operand; only bits 31:0 are used |
| ctl_we | input | 1 | Software write strobe for the control register |
| ctl_wdata | input | 32 | Software write data for the control register |
| result | output | 64 | Packed, sign-extended destination word |
| res_valid | output | 1 | One-cycle pulse marking `result` as valid |
| unit_off_exc | output | 1 | One-cycle pulse for a start while the unit is disabled |
| ctl_reg | output | 32 | Control register; bit 20 is the sticky overflow flag |

## Verification
The hardest case to reach from the ports is a software write to the control register landing in the same clock edge as an overflowing add. The bench drives `ctl_we` and `start` in the same cycle. It writes a pattern with bit 20 clear and supplies operands that overflow, then checks that bit 20 comes out set and that every other bit matches the written pattern. A second class of stimulus sweeps the four boundary values 0x7FFF, 0x8000, 0xFFFF and 0x0001 across both lanes and both modes. The flag is cleared before each add, so every single operation's overflow decision can be seen on its own.

// File: rtl/q15_pkg.sv
// Shared definitions for the paired Q15 adder.
// Assumes: the mode encoding below is fixed at the block's edge (0 = wrap, 1 = saturate).
package q15_pkg;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SAT  = 1'b1
    } add_mode_e;

endpackage

// File: rtl/q15_lane.sv
// One signed fixed-point lane. It adds two W-bit two's-complement values at
// W+1 bits, flags an out-of-range sum, and returns either the wrapped sum or
// the clamped limit, depending on the mode.
// Assumes: the operands are valid two's-complement values. The lane is purely
// combinational.
module q15_lane
    import q15_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  add_mode_e    mode,
    output logic [W-1:0] y,
    output logic         ovf
);

    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_ext;

    // Widen both operands by their sign bit and add them.
    always_comb begin
        sum_ext = {a[W-1], a} + {b[W-1], b};
    end

    // Detect overflow and choose between the wrapped sum and a clamped limit.
    always_comb begin
        ovf = sum_ext[W] ^ sum_ext[W-1];
        if (ovf && (mode == MODE_SAT)) begin
            y = sum_ext[W] ? NEG_LIMIT : POS_LIMIT;
        end else begin
            y = sum_ext[W-1:0];
        end
    end

endmodule

// File: rtl/q15_pack.sv
// Builds the destination word. The lane results are concatenated, and the
// remaining high bits are filled with the sign of the topmost lane.
// Assumes: XLEN is larger than LANES*W.
module q15_pack #(
    parameter int W     = 16,
    parameter int LANES = 2,
    parameter int XLEN  = 64
) (
    input  logic [LANES*W-1:0] lanes,
    output logic [XLEN-1:0]    word
);

    localparam int PACK_W = LANES * W;
    localparam int EXT_W  = XLEN - PACK_W;

    // Replicate the top lane's sign bit across the unused high bits.
    always_comb begin
        word = {{EXT_W{lanes[PACK_W-1]}}, lanes};
    end

endmodule

// File: rtl/q15_ctl_reg.sv
// Control register that holds the sticky overflow flag. Software can write
// the whole register. An overflow from the datapath sets the flag bit, and
// that set takes priority over a software write in the same cycle.
// Assumes: set_ovf is high only for accepted operations.
module q15_ctl_reg #(
    parameter int CTL_W   = 32,
    parameter int OVF_BIT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             set_ovf,
    output logic [CTL_W-1:0] q
);

    logic [CTL_W-1:0] nxt;

    // Take the software write if there is one, then apply the overflow set on top.
    always_comb begin
        nxt = wr_en ? wr_data : q;
        if (set_ovf) begin
            nxt[OVF_BIT] = 1'b1;
        end
    end

    // Register the next value and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/q15_pair_adder.sv
// Paired Q15 adder execution slice. It takes the low LANES*W bits of each
// operand, adds them lane by lane in wrap or saturating mode, packs the
// sign-extended result into a register, and pulses res_valid one cycle
// after an accepted start. A start while the unit is disabled pulses
// unit_off_exc instead and leaves the result and control state alone.
// Assumes: start is a single-cycle request and needs no back-pressure.
module q15_pair_adder
    import q15_pkg::*;
#(
    parameter int W       = 16,
    parameter int LANES   = 2,
    parameter int XLEN    = 64,
    parameter int CTL_W   = 32,
    parameter int OVF_BIT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dsp_en,
    input  logic             sat_mode,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [XLEN-1:0]  result,
    output logic             res_valid,
    output logic             unit_off_exc,
    output logic [CTL_W-1:0] ctl_reg
);

    localparam int PACK_W = LANES * W;

    add_mode_e         mode;
    logic [PACK_W-1:0] lane_y;
    logic [LANES-1:0]  lane_ovf;
    logic [XLEN-1:0]   packed_word;
    logic              accept;
    logic              refuse;
    logic              any_ovf;
    logic              unused_hi;

    // Decode the mode and split requests into accepted and refused ones.
    always_comb begin
        mode    = add_mode_e'(sat_mode);
        accept  = start & dsp_en;
        refuse  = start & ~dsp_en;
        any_ovf = |lane_ovf;
    end

    // The operand bits above the packed lanes are not used.
    assign unused_hi = ^{src_a[XLEN-1:PACK_W], src_b[XLEN-1:PACK_W]};

    // One independent adder per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        q15_lane #(.W(W)) u_lane (
            .a    (src_a[g*W +: W]),
            .b    (src_b[g*W +: W]),
            .mode (mode),
            .y    (lane_y[g*W +: W]),
            .ovf  (lane_ovf[g])
        );
    end

    q15_pack #(.W(W), .LANES(LANES), .XLEN(XLEN)) u_pack (
        .lanes (lane_y),
        .word  (packed_word)
    );

    q15_ctl_reg #(.CTL_W(CTL_W), .OVF_BIT(OVF_BIT)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .set_ovf (accept & any_ovf),
        .q       (ctl_reg)
    );

    // Capture the result and drive the single-cycle valid and exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            res_valid    <= 1'b0;
            unit_off_exc <= 1'b0;
        end else begin
            res_valid    <= accept;
            unit_off_exc <= refuse;
            if (accept) begin
                result <= packed_word;
            end
        end
    end

endmodule

// File: rtl/q15_pair_adder_chk.sv
// Checker for the paired Q15 adder, attached to the top module by bind.
// It observes only the ports.
module q15_pair_adder_chk #(
    parameter int XLEN    = 64,
    parameter int CTL_W   = 32,
    parameter int OVF_BIT = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             dsp_en,
    input logic             ctl_we,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic [XLEN-1:0]  result,
    input logic             res_valid,
    input logic             unit_off_exc,
    input logic [CTL_W-1:0] ctl_reg
);

    // R8: an accepted start is followed by valid.
    assert_valid_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dsp_en) |=> res_valid);

    // R8: no accepted start means no valid on the next cycle.
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && dsp_en) |=> !res_valid);

    // R6: a refused start raises the exception and produces no result.
    assert_refused_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dsp_en) |=> (unit_off_exc && !res_valid && $stable(result)));

    // R6: a refused start without a software write leaves the control register alone.
    assert_refused_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dsp_en && !ctl_we) |=> $stable(ctl_reg));

    // R4: the high half of a valid result copies the sign of bit 31.
    assert_sign_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (result[XLEN-1:32] == {(XLEN-32){result[31]}}));

    // R5: without a software write, the flag never falls.
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_reg[OVF_BIT] && !ctl_we) |=> ctl_reg[OVF_BIT]);

    // R5: the flag rises only because of a completed add or a software write.
    assert_flag_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_reg[OVF_BIT]) |-> (res_valid || ($past(ctl_we) && $past(ctl_wdata[OVF_BIT]))));

    // R7: a software write with no start in the same cycle lands exactly.
    assert_sw_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !start) |=> (ctl_reg == $past(ctl_wdata)));

    // R9: reset clears the outputs on the following cycle.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !unit_off_exc && (ctl_reg == '0) && (result == '0)));

endmodule

bind q15_pair_adder q15_pair_adder_chk #(
    .XLEN    (XLEN),
    .CTL_W   (CTL_W),
    .OVF_BIT (OVF_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .dsp_en       (dsp_en),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .result       (result),
    .res_valid    (res_valid),
    .unit_off_exc (unit_off_exc),
    .ctl_reg      (ctl_reg)
);

// File: tb/q15_pair_adder_test.sv
// Directed bench for the paired Q15 adder. Each scenario is a task that checks its own results.
module q15_pair_adder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dsp_en = 1'b1;
    logic        sat_mode = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [63:0] result;
    logic        res_valid;
    logic        unit_off_exc;
    logic [31:0] ctl_reg;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    q15_pair_adder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dsp_en       (dsp_en),
        .sat_mode     (sat_mode),
        .src_a        (src_a),
        .src_b        (src_b),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .result       (result),
        .res_valid    (res_valid),
        .unit_off_exc (unit_off_exc),
        .ctl_reg      (ctl_reg)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference lane computed with integer arithmetic: returns {ovf, value}.
    function automatic logic [16:0] ref_lane(input logic [15:0] a, input logic [15:0] b, input bit sat);
        int s;
        bit ov;
        logic [15:0] v;
        s  = int'($signed(a)) + int'($signed(b));
        ov = (s > 32767) || (s < -32768);
        if (sat && ov) v = (s > 0) ? 16'h7FFF : 16'h8000;
        else           v = 16'(s);
        return {ov, v};
    endfunction

    function automatic logic [63:0] ref_word(input logic [15:0] hi, input logic [15:0] lo);
        return {{32{hi[15]}}, hi, lo};
    endfunction

    // Issue one start and leave the outputs ready to sample at the next negedge.
    task automatic issue(input logic [63:0] a, input logic [63:0] b, input bit sat, input bit en);
        @(negedge clk);
        src_a = a; src_b = b; sat_mode = sat; dsp_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0; dsp_en = 1'b1;
    endtask

    task automatic sw_write(input logic [31:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 result", result, 64'h0);
        check("R9 valid", {63'h0, res_valid}, 64'h0);
        check("R9 exc", {63'h0, unit_off_exc}, 64'h0);
        check("R9 ctl", {32'h0, ctl_reg}, 64'h0);
    endtask

    // Boundary sweep over both lanes and both modes (R1, R2, R3, R4, R5).
    task automatic t_boundary_sweep();
        logic [15:0] vals [4];
        vals[0] = 16'h7FFF; vals[1] = 16'h8000; vals[2] = 16'hFFFF; vals[3] = 16'h0001;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [16:0] rh, rl;
                    rh = ref_lane(vals[i], vals[j], m[0]);
                    rl = ref_lane(vals[j], vals[i], m[0]);
                    sw_write(32'h0);
                    issue({32'h0, vals[i], vals[j]}, {32'h0, vals[j], vals[i]}, m[0], 1'b1);
                    check(m[0] ? "R3 sat result" : "R1 wrap result", result, ref_word(rh[15:0], rl[15:0]));
                    check("R8 valid", {63'h0, res_valid}, 64'h1);
                    check("R2 R5 flag", {63'h0, ctl_reg[20]}, {63'h0, rh[16] | rl[16]});
                end
            end
        end
    endtask

    // Lower-lane carry must not reach the upper lane; check a mid-range wrap too.
    task automatic t_lane_isolation();
        sw_write(32'h0);
        issue(64'h0000_0000_1234_FFFF, 64'h0000_0000_0001_0001, 1'b0, 1'b1);
        check("R1 no carry", result, 64'h0000_0000_1235_0000);
        check("R2 no ovf", {63'h0, ctl_reg[20]}, 64'h0);
        issue(64'h0000_0000_4000_C000, 64'h0000_0000_4000_C000, 1'b0, 1'b1);
        check("R1 R4 wrap pack", result, 64'hFFFF_FFFF_8000_8000);
        check("R5 wrap ovf", {63'h0, ctl_reg[20]}, 64'h1);
    endtask

    task automatic t_upper_ignored();
        sw_write(32'h0);
        issue(64'hDEAD_BEEF_0010_0020, 64'h7FFF_FFFF_0003_0004, 1'b1, 1'b1);
        check("R10 result", result, 64'h0000_0000_0013_0024);
        check("R10 ctl", {32'h0, ctl_reg}, 64'h0);
    endtask

    task automatic t_sticky();
        sw_write(32'h0);
        issue(64'h0000_0000_7FFF_0000, 64'h0000_0000_0001_0000, 1'b1, 1'b1);
        check("R3 clamp", result, 64'h0000_0000_7FFF_0000);
        issue(64'h0000_0000_0001_0001, 64'h0000_0000_0001_0001, 1'b1, 1'b1);
        check("R5 sticky", {63'h0, ctl_reg[20]}, 64'h1);
        sw_write(32'h0000_00A5);
        check("R7 sw clear", {32'h0, ctl_reg}, 64'h0000_00A5);
    endtask

    task automatic t_disabled();
        logic [63:0] prev_res;
        logic [31:0] prev_ctl;
        sw_write(32'h0);
        issue(64'h0000_0000_0002_0003, 64'h0000_0000_0004_0005, 1'b0, 1'b1);
        prev_res = result;
        prev_ctl = ctl_reg;
        issue(64'h0000_0000_8000_8000, 64'h0000_0000_8000_8000, 1'b1, 1'b0);
        check("R6 exc", {63'h0, unit_off_exc}, 64'h1);
        check("R6 no valid", {63'h0, res_valid}, 64'h0);
        check("R6 result held", result, prev_res);
        check("R6 ctl held", {32'h0, ctl_reg}, {32'h0, prev_ctl});
        @(negedge clk);
        check("R6 exc one cycle", {63'h0, unit_off_exc}, 64'h0);
    endtask

    // Software write and overflowing add land on the same edge.
    task automatic t_collision();
        sw_write(32'h0);
        @(negedge clk);
        src_a = 64'h0000_0000_8000_0000; src_b = 64'h0000_0000_8000_0000;
        sat_mode = 1'b0; dsp_en = 1'b1; start = 1'b1;
        ctl_we = 1'b1; ctl_wdata = 32'h0000_0F0F;
        @(negedge clk);
        start = 1'b0; ctl_we = 1'b0;
        check("R7 collision", {32'h0, ctl_reg}, 64'h0010_0F0F);
        check("R4 neg wrap", result, 64'h0);
    endtask

    task automatic t_valid_pulse();
        issue(64'h1, 64'h1, 1'b0, 1'b1);
        check("R8 valid high", {63'h0, res_valid}, 64'h1);
        @(negedge clk);
        check("R8 valid one cycle", {63'h0, res_valid}, 64'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_boundary_sweep();
        t_lane_isolation();
        t_upper_ignored();
        t_sticky();
        t_disabled();
        t_collision();
        t_valid_pulse();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule